// File: doc/BRIEF.md
# Line Sync Clamp and Burst Strobe Generator

This block produces the per-line timing strobes that a composite video encoder needs around horizontal sync. It runs on the encoder's reference clock and watches an asynchronous, active-low sync input. On each sync leading (falling) edge it restarts a line position counter. Three pulses are decoded from that count: a short modulator offset restore strobe, an input DC clamp strobe, and a delay-line reset strobe that doubles as the burst gate.

A standard-select input picks one of two cycle tables. Table A is for the 14.318180 MHz clock. Table B is for the 17.734475 MHz clock. The block also measures how long sync stays low. The burst gate is passed only when that width falls inside the window allowed for the selected standard. Every delay and width is a parameter, held as a whole number of clock cycles.

Top module: `line_strobe_gen`

## Requirements
- R1: After reset, and until the first sync falling edge, all five outputs are low.
- R2: Let edge N be the first clock edge at which sync_n is sampled low after being sampled high. The line position after edge N+2+p is p. An output is high after an edge exactly when the position lies in that output's half-open window [start, start+length).
- R3: mod_restore uses start 6 and length 2 with std_a=1, and start 5 and length 2 with std_a=0.
- R4: in_clamp uses start 77 and length 36 with std_a=1, and start 99 and length 41 with std_a=0.
- R5: dl_reset uses start 82 and length 36 with std_a=1, and start 103 and length 41 with std_a=0.
- R6: The sync width W is the number of consecutive clock edges at which sync_n is sampled low. burst_ok is cleared after edge N+2 and updated after edge N+W+2. It becomes 1 when W lies in 40..76 inclusive (std_a=1) or 59..96 inclusive (std_a=0), and 0 otherwise. It then holds until the next sync edge.
- R7: burst_gate is high exactly when dl_reset and burst_ok are both high in the same cycle.
- R8: std_a is sampled only at the edge where the line position restarts, edge N+2. A change at any other time has no effect on the current line.
- R9: A new sync falling edge during a line restarts the position at 0 and clears burst_ok, whatever pulse is in progress.
- R10: The line position saturates at 255 and does not wrap, so no pulse recurs on a long line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Asynchronous horizontal sync, active low |
| std_a | input | 1 | 1 selects table A (14.318 MHz), 0 selects table B (17.734 MHz) |
| mod_restore | output | 1 | Modulator offset restore strobe |
| in_clamp | output | 1 | Input DC clamp strobe |
| dl_reset | output | 1 | Delay-line reset strobe |
| burst_gate | output | 1 | dl_reset qualified by a valid sync width |
| burst_ok | output | 1 | Measured sync width was in the valid window |

## Verification
The assertions check four rules on every cycle:
- a rising modulator strobe coincides with its table start position;
- the clamp strobe ends only at its table end or on a restart;
- the gate never appears without both dl_reset and burst_ok;
- burst_ok rises only for a width inside the window, and the block stays silent before the first sync.

Only the bench scenarios can show the rest: the exact cycle placement of every pulse in both tables, widths one cycle inside and outside each limit, ignoring a mid-line standard change, restart during a pulse, and the absence of a wrapped pulse on a long line.

// File: rtl/line_strobe_gen.sv
module line_strobe_gen #(
  parameter int CW        = 8,
  parameter int A_MOD_AT  = 6,   parameter int A_MOD_LEN = 2,
  parameter int A_CLP_AT  = 77,  parameter int A_CLP_LEN = 36,
  parameter int A_DLR_AT  = 82,  parameter int A_DLR_LEN = 36,
  parameter int A_SW_MIN  = 40,  parameter int A_SW_MAX  = 76,
  parameter int B_MOD_AT  = 5,   parameter int B_MOD_LEN = 2,
  parameter int B_CLP_AT  = 99,  parameter int B_CLP_LEN = 41,
  parameter int B_DLR_AT  = 103, parameter int B_DLR_LEN = 41,
  parameter int B_SW_MIN  = 59,  parameter int B_SW_MAX  = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  input  logic std_a,
  output logic mod_restore,
  output logic in_clamp,
  output logic dl_reset,
  output logic burst_gate,
  output logic burst_ok
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic s1, s2, s3;
  logic [CW-1:0] cnt, meas, cnt_nx, meas_nx;
  logic active, armed, std_q, std_nx, ok_nx, width_good;

  wire fall = s3 & ~s2;
  wire rise = ~s3 & s2;

  function automatic logic inwin(logic [CW-1:0] c, int at, int len);
    return (c >= CW'(at)) && (c < CW'(at + len));
  endfunction

  assign std_nx  = fall ? std_a : std_q;
  assign cnt_nx  = fall ? '0 : (cnt == CMAX ? cnt : cnt + 1'b1);
  assign meas_nx = fall ? CW'(1) : ((!s2 && meas != CMAX) ? meas + 1'b1 : meas);

  assign width_good = std_q ? (meas >= CW'(A_SW_MIN) && meas <= CW'(A_SW_MAX))
                            : (meas >= CW'(B_SW_MIN) && meas <= CW'(B_SW_MAX));
  assign ok_nx = fall ? 1'b0 : ((rise && armed) ? width_good : burst_ok);

  wire act_nx = active | fall;
  wire mod_nx = act_nx && (std_nx ? inwin(cnt_nx, A_MOD_AT, A_MOD_LEN) : inwin(cnt_nx, B_MOD_AT, B_MOD_LEN));
  wire clp_nx = act_nx && (std_nx ? inwin(cnt_nx, A_CLP_AT, A_CLP_LEN) : inwin(cnt_nx, B_CLP_AT, B_CLP_LEN));
  wire dlr_nx = act_nx && (std_nx ? inwin(cnt_nx, A_DLR_AT, A_DLR_LEN) : inwin(cnt_nx, B_DLR_AT, B_DLR_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s1, s2, s3} <= 3'b111;
      cnt <= '0;  meas <= '0;
      active <= 1'b0;  armed <= 1'b0;  std_q <= 1'b0;
      mod_restore <= 1'b0;  in_clamp <= 1'b0;  dl_reset <= 1'b0;
      burst_gate <= 1'b0;  burst_ok <= 1'b0;
    end else begin
      s1 <= sync_n;  s2 <= s1;  s3 <= s2;
      cnt <= cnt_nx;  meas <= meas_nx;
      active <= act_nx;  std_q <= std_nx;
      armed <= fall ? 1'b1 : (rise ? 1'b0 : armed);
      mod_restore <= mod_nx;
      in_clamp <= clp_nx;
      dl_reset <= dlr_nx;
      burst_ok <= ok_nx;
      burst_gate <= dlr_nx && ok_nx;
    end
  end

  a_r1_silent_before_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !(mod_restore || in_clamp || dl_reset || burst_gate || burst_ok));

  a_r3_mod_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_restore) |-> cnt == (std_q ? CW'(A_MOD_AT) : CW'(B_MOD_AT)));

  a_r4_clamp_end_position: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(in_clamp) && cnt != '0) |->
      cnt == (std_q ? CW'(A_CLP_AT + A_CLP_LEN) : CW'(B_CLP_AT + B_CLP_LEN)));

  a_r6_ok_only_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_ok) |-> (std_q ? (meas >= CW'(A_SW_MIN) && meas <= CW'(A_SW_MAX))
                               : (meas >= CW'(B_SW_MIN) && meas <= CW'(B_SW_MAX))));

  a_r7_gate_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    burst_gate |-> (dl_reset && burst_ok));
endmodule

// File: tb/test_line_strobe_gen.sv
module test_line_strobe_gen;
  logic clk = 1'b0, rst_n = 1'b0, sync_n = 1'b1, std_a = 1'b1;
  logic mod_restore, in_clamp, dl_reset, burst_gate, burst_ok;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  string tag = "R1";

  line_strobe_gen i_line_strobe_gen (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .std_a(std_a),
    .mod_restore(mod_restore), .in_clamp(in_clamp), .dl_reset(dl_reset),
    .burst_gate(burst_gate), .burst_ok(burst_ok));

  always #10 clk = ~clk;

  // behavioural reference: samples, line position, latched standard, width verdict
  bit hist[$];
  int tc, e, efall;
  bit act, stdm, okm, armm;

  function automatic bit win(int p, int at, int len);
    return act && p >= at && p < at + len;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{1'b1, 1'b1, 1'b1, 1'b1};
      act = 0; tc = 0; okm = 0; armm = 0; stdm = 0; e = 0; efall = 0;
    end else begin
      e++;
      hist.push_front(sync_n);
      void'(hist.pop_back());
      if (hist[3] && !hist[2]) begin
        tc = 0; act = 1; stdm = std_a; okm = 0; armm = 1; efall = e;
      end else if (act && tc < 255) tc++;
      if (!hist[3] && hist[2] && armm) begin
        int w;
        w = e - efall;
        armm = 0;
        okm = stdm ? (w >= 40 && w <= 76) : (w >= 59 && w <= 96);
      end
    end
  end

  task automatic chk(string req, string nm, logic got, bit exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s/%s %s at cycle %0d: got %b expected %b", req, tag, nm, cyc, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit em, ec, ed;
      em = stdm ? win(tc, 6, 2)   : win(tc, 5, 2);
      ec = stdm ? win(tc, 77, 36) : win(tc, 99, 41);
      ed = stdm ? win(tc, 82, 36) : win(tc, 103, 41);
      chk("R3", "mod_restore", mod_restore, em);
      chk("R4", "in_clamp", in_clamp, ec);
      chk("R5", "dl_reset", dl_reset, ed);
      chk("R6", "burst_ok", burst_ok, okm);
      chk("R7", "burst_gate", burst_gate, ed && okm);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic line(int w, bit s, int gap);
    @(negedge clk);
    std_a = s;
    repeat (3) @(negedge clk);
    sync_n = 1'b0;
    repeat (w) @(negedge clk);
    sync_n = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if ({mod_restore, in_clamp, dl_reset, burst_gate, burst_ok} !== 5'b0) begin
      bad++;
      $display("FAIL R1 outputs during reset got %b expected 00000",
               {mod_restore, in_clamp, dl_reset, burst_gate, burst_ok});
    end
    rst_n = 1'b1;
    tag = "R1";  repeat (20) @(negedge clk);
    tag = "R2";  line(60, 1'b1, 250);  line(70, 1'b0, 250);
    tag = "R6a"; line(39, 1'b1, 200);  line(40, 1'b1, 200);
                 line(76, 1'b1, 200);  line(77, 1'b1, 200);
    tag = "R6b"; line(58, 1'b0, 200);  line(59, 1'b0, 200);
                 line(96, 1'b0, 200);  line(97, 1'b0, 200);
    tag = "R8";
    @(negedge clk); std_a = 1'b1;
    repeat (3) @(negedge clk); sync_n = 1'b0;
    repeat (50) @(negedge clk); std_a = 1'b0;
    repeat (10) @(negedge clk); sync_n = 1'b1;
    repeat (30) @(negedge clk); std_a = 1'b1;
    repeat (200) @(negedge clk); std_a = 1'b0;
    tag = "R9";  line(60, 1'b1, 30);  line(10, 1'b0, 250);
                 line(65, 1'b0, 95);  line(45, 1'b1, 250);
    tag = "R10"; line(60, 1'b1, 700);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule